// File: doc/BRIEF.md
# Instruction Decoder with Illegal-Instruction Detection

This block turns one 32-bit instruction word into the fields and control signals that the execute stages of a small processor need. The top 6 bits hold the opcode. The decoder sorts each opcode into a register-operand format or an immediate format. It extracts the register indices, the shift amount, the 16-bit immediate and the 26-bit absolute-address field. It then produces the ALU operation, the memory access kind, size and signedness, the branch condition, the register and flag write enables, and the interrupt, interrupt-return and halt requests.

Alongside this, the decoder checks each word against the rules of its format and raises `illegal` when a rule is broken. An opcode outside the defined map is illegal. A nonzero shift amount on a register-format instruction that does not shift is illegal. Every register field that an opcode does not use must hold the reserved "no register" index, and any other value there is illegal. An interrupt whose code does not fit in 8 bits is illegal. When `illegal` is set, every control that would change machine state is forced low, so the exception logic downstream only has to look at one flag.

A parameter selects one of two output forms. The decode can leave through one register stage, qualified by a valid bit, or it can leave combinationally.

Top module: `instr_decoder`

## Requirements
- R1: `fmt` reports 0 for register-format opcodes, 1 for immediate-format opcodes and 3 for undefined opcodes; code 2 (absolute-address format) is not produced by the current map. The register-format opcodes are 0x00–0x02, 0x14–0x21, 0x23 and 0x24. The immediate-format opcodes are 0x03–0x13, 0x22, 0x25 and 0x26.
- R2: Every opcode from 0x27 to 0x3F raises `illegal`.
- R3: On a register-format opcode other than 0x17 (shift left) and 0x18 (shift right), a nonzero shift field in bits 10..6 raises `illegal`. Both shift opcodes accept any shift value, which appears on `shamt`.
- R4: The "no register" index is 31, and each opcode fixes which fields must hold it. Field A is bits 25..21, field B is bits 20..16, and field C is bits 15..11 (register format only). The required fields are:
  - A, B and C on 0x00, 0x23 and 0x24;
  - B on 0x01, 0x02, 0x0D–0x13, 0x15, 0x16 and 0x1D;
  - C on 0x14;
  - A on 0x0B and 0x0C;
  - A and B on 0x22.
  Any other value in a required field raises `illegal`. All other fields of defined opcodes are unchecked.
- R5: Opcode 0x22 sets `int_req`, and `int_code` carries immediate bits 7..0. Nonzero immediate bits 15..8 on 0x22 raise `illegal`.
- R6: `src_a` is bits 25..21, `src_b` is bits 20..16, `shamt` is bits 10..6, `imm` is bits 15..0 and `jaddr` is bits 25..0. `dst` is bits 15..11 in register format and bits 20..16 in immediate format.
- R7: Opcodes 0x03–0x07 set `mem_rd` and 0x08–0x0A set `mem_wr`. `mem_size` is 0 for byte (0x03, 0x04, 0x08), 1 for halfword (0x05, 0x06, 0x09) and 2 for word (0x07, 0x0A). `mem_signed` is set only for 0x04 and 0x06.
- R8: Opcodes 0x0D–0x13 set `br_en`. `br_cond` is 0 for always, 1 for equal, 2 for not equal, 3 for greater, 4 for greater-or-equal, 5 for less and 6 for less-or-equal, in opcode order.
- R9: `alu_op` uses these codes:
  - 0: none (0x00, 0x22–0x24 and undefined opcodes);
  - 1: move (0x01);
  - 2: sign-extending move (0x02);
  - 3: add (loads, stores, jumps, 0x19, 0x25);
  - 4: subtract (0x1A, 0x26);
  - 5 to 11: AND, OR, NOT, XOR, NAND, NOR, XNOR (0x1B–0x21);
  - 12: shift left (0x17);
  - 13: shift right (0x18);
  - 14: increment (0x15);
  - 15: decrement (0x16);
  - 16: compare (0x14);
  - 17: low-half literal (0x0B);
  - 18: high-half literal (0x0C).
- R10: `wb_en` is set for 0x01–0x07, 0x0B, 0x0C, 0x15–0x21, 0x25 and 0x26. `flag_wr` is set only for 0x14.
- R11: Opcode 0x23 sets `irt` and opcode 0x24 sets `halt`.
- R12: While `illegal` is set, `wb_en`, `flag_wr`, `mem_rd`, `mem_wr`, `br_en`, `int_req`, `irt` and `halt` are all 0.
- R13: With the registered output form, the decode of the word presented with `in_valid` appears one clock later, and `out_valid` repeats `in_valid` one clock later. Reset clears `out_valid` and every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word qualifier |
| instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded outputs qualifier |
| fmt | output | 2 | Format code |
| src_a | output | 5 | Register field A |
| src_b | output | 5 | Register field B |
| dst | output | 5 | Destination register index |
| shamt | output | 5 | Shift amount field |
| imm | output | 16 | Immediate field |
| jaddr | output | 26 | Absolute-address field |
| alu_op | output | 5 | ALU operation code |
| mem_rd | output | 1 | Load request |
| mem_wr | output | 1 | Store request |
| mem_size | output | 2 | Access size code |
| mem_signed | output | 1 | Sign-extend loaded data |
| br_en | output | 1 | Branch instruction |
| br_cond | output | 3 | Branch condition code |
| wb_en | output | 1 | Register writeback enable |
| flag_wr | output | 1 | Status flag update |
| int_req | output | 1 | Software interrupt request |
| int_code | output | 8 | Software interrupt code |
| irt | output | 1 | Return from interrupt |
| halt | output | 1 | Halt request |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The bench builds the decoder with its defaults: the registered output form (`REG_OUT` = 1) and a "no register" index of 31 (`NOREG` = 31). The registered form brings the one-cycle latency, the `out_valid` pipeline and the reset clearing of the outputs within reach of the checks. The index of 31 lets a sweep over all 64 opcode values use all-ones register fields as a legal filler, so that format, ALU code, writeback and legality are compared for every opcode. Directed words then place non-filler values in each checked field, and nonzero shift, high immediate bits and wide shift values, so that every illegal cause and its suppression of the state-changing controls are observed at the ports.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int RIDX_W  = 5;
    localparam int SHAMT_W = 5;
    localparam int IMM_W   = 16;
    localparam int ADDR_W  = 26;
    localparam int CODE_W  = 8;

    typedef enum logic [1:0] {
        FMT_R    = 2'd0,
        FMT_I    = 2'd1,
        FMT_J    = 2'd2,
        FMT_NONE = 2'd3
    } fmt_e;

    typedef enum logic [4:0] {
        ALU_NOP  = 5'd0,
        ALU_PASS = 5'd1,
        ALU_SEXT = 5'd2,
        ALU_ADD  = 5'd3,
        ALU_SUB  = 5'd4,
        ALU_AND  = 5'd5,
        ALU_OR   = 5'd6,
        ALU_NOT  = 5'd7,
        ALU_XOR  = 5'd8,
        ALU_NAND = 5'd9,
        ALU_NOR  = 5'd10,
        ALU_XNOR = 5'd11,
        ALU_SHL  = 5'd12,
        ALU_SHR  = 5'd13,
        ALU_INC  = 5'd14,
        ALU_DEC  = 5'd15,
        ALU_CMP  = 5'd16,
        ALU_LLO  = 5'd17,
        ALU_LHI  = 5'd18
    } alu_e;

    typedef enum logic [2:0] {
        BRC_ALW = 3'd0,
        BRC_EQ  = 3'd1,
        BRC_NE  = 3'd2,
        BRC_GT  = 3'd3,
        BRC_GE  = 3'd4,
        BRC_LT  = 3'd5,
        BRC_LE  = 3'd6
    } brc_e;

    typedef enum logic [1:0] {
        MSZ_B = 2'd0,
        MSZ_H = 2'd1,
        MSZ_W = 2'd2
    } msz_e;

    localparam logic [OPC_W-1:0] OP_NOP  = 6'h00;
    localparam logic [OPC_W-1:0] OP_MOV  = 6'h01;
    localparam logic [OPC_W-1:0] OP_MOVS = 6'h02;
    localparam logic [OPC_W-1:0] OP_LDB  = 6'h03;
    localparam logic [OPC_W-1:0] OP_LDBS = 6'h04;
    localparam logic [OPC_W-1:0] OP_LDH  = 6'h05;
    localparam logic [OPC_W-1:0] OP_LDHS = 6'h06;
    localparam logic [OPC_W-1:0] OP_LDW  = 6'h07;
    localparam logic [OPC_W-1:0] OP_STB  = 6'h08;
    localparam logic [OPC_W-1:0] OP_STH  = 6'h09;
    localparam logic [OPC_W-1:0] OP_STW  = 6'h0A;
    localparam logic [OPC_W-1:0] OP_LLO  = 6'h0B;
    localparam logic [OPC_W-1:0] OP_LHI  = 6'h0C;
    localparam logic [OPC_W-1:0] OP_JMP  = 6'h0D;
    localparam logic [OPC_W-1:0] OP_JEQ  = 6'h0E;
    localparam logic [OPC_W-1:0] OP_JNE  = 6'h0F;
    localparam logic [OPC_W-1:0] OP_JGT  = 6'h10;
    localparam logic [OPC_W-1:0] OP_JGE  = 6'h11;
    localparam logic [OPC_W-1:0] OP_JLT  = 6'h12;
    localparam logic [OPC_W-1:0] OP_JLE  = 6'h13;
    localparam logic [OPC_W-1:0] OP_CMP  = 6'h14;
    localparam logic [OPC_W-1:0] OP_INC  = 6'h15;
    localparam logic [OPC_W-1:0] OP_DEC  = 6'h16;
    localparam logic [OPC_W-1:0] OP_SHL  = 6'h17;
    localparam logic [OPC_W-1:0] OP_SHR  = 6'h18;
    localparam logic [OPC_W-1:0] OP_ADD  = 6'h19;
    localparam logic [OPC_W-1:0] OP_SUB  = 6'h1A;
    localparam logic [OPC_W-1:0] OP_AND  = 6'h1B;
    localparam logic [OPC_W-1:0] OP_OR   = 6'h1C;
    localparam logic [OPC_W-1:0] OP_NOT  = 6'h1D;
    localparam logic [OPC_W-1:0] OP_XOR  = 6'h1E;
    localparam logic [OPC_W-1:0] OP_NAND = 6'h1F;
    localparam logic [OPC_W-1:0] OP_NOR  = 6'h20;
    localparam logic [OPC_W-1:0] OP_XNOR = 6'h21;
    localparam logic [OPC_W-1:0] OP_INT  = 6'h22;
    localparam logic [OPC_W-1:0] OP_IRT  = 6'h23;
    localparam logic [OPC_W-1:0] OP_HLT  = 6'h24;
    localparam logic [OPC_W-1:0] OP_IADD = 6'h25;
    localparam logic [OPC_W-1:0] OP_ISUB = 6'h26;

    // Per-opcode control word; noreg_req bit 2 = field A, 1 = field B, 0 = field C
    typedef struct packed {
        fmt_e       fmt;
        alu_e       alu;
        logic       mem_rd;
        logic       mem_wr;
        msz_e       msz;
        logic       mem_sgn;
        logic       br_en;
        brc_e       brc;
        logic       wb_en;
        logic       flag_wr;
        logic       is_int;
        logic       is_irt;
        logic       is_halt;
        logic       defined;
        logic       shift_ok;
        logic [2:0] noreg_req;
    } ctrl_t;

    typedef struct packed {
        fmt_e               fmt;
        logic [RIDX_W-1:0]  src_a;
        logic [RIDX_W-1:0]  src_b;
        logic [RIDX_W-1:0]  dst;
        logic [SHAMT_W-1:0] shamt;
        logic [IMM_W-1:0]   imm;
        logic [ADDR_W-1:0]  jaddr;
        alu_e               alu;
        logic               mem_rd;
        logic               mem_wr;
        msz_e               msz;
        logic               mem_sgn;
        logic               br_en;
        brc_e               brc;
        logic               wb_en;
        logic               flag_wr;
        logic               int_req;
        logic [CODE_W-1:0]  int_code;
        logic               irt;
        logic               halt;
        logic               illegal;
    } dec_t;

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [OPC_W-1:0]   opcode,
    output logic [RIDX_W-1:0]  fld_a,
    output logic [RIDX_W-1:0]  fld_b,
    output logic [RIDX_W-1:0]  fld_c,
    output logic [SHAMT_W-1:0] shamt,
    output logic [IMM_W-1:0]   imm,
    output logic [ADDR_W-1:0]  jaddr
);
    localparam int OPC_LO   = INSTR_W - OPC_W;
    localparam int A_LO     = OPC_LO - RIDX_W;
    localparam int B_LO     = A_LO - RIDX_W;
    localparam int C_LO     = B_LO - RIDX_W;
    localparam int SHAMT_LO = C_LO - SHAMT_W;

    assign opcode = instr[INSTR_W-1:OPC_LO];
    assign fld_a  = instr[OPC_LO-1:A_LO];
    assign fld_b  = instr[A_LO-1:B_LO];
    assign fld_c  = instr[B_LO-1:C_LO];
    assign shamt  = instr[C_LO-1:SHAMT_LO];
    assign imm    = instr[IMM_W-1:0];
    assign jaddr  = instr[ADDR_W-1:0];

endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);
    always_comb begin
        ctrl         = '0;
        ctrl.fmt     = FMT_NONE;
        ctrl.alu     = ALU_NOP;
        ctrl.msz     = MSZ_B;
        ctrl.brc     = BRC_ALW;
        case (opcode)
            OP_NOP, OP_IRT, OP_HLT: begin
                ctrl.fmt       = FMT_R;
                ctrl.defined   = 1'b1;
                ctrl.noreg_req = 3'b111;
                ctrl.is_irt    = (opcode == OP_IRT);
                ctrl.is_halt   = (opcode == OP_HLT);
            end
            OP_MOV, OP_MOVS: begin
                ctrl.fmt       = FMT_R;
                ctrl.defined   = 1'b1;
                ctrl.alu       = (opcode == OP_MOVS) ? ALU_SEXT : ALU_PASS;
                ctrl.wb_en     = 1'b1;
                ctrl.noreg_req = 3'b010;
            end
            OP_LDB, OP_LDBS, OP_LDH, OP_LDHS, OP_LDW: begin
                ctrl.fmt     = FMT_I;
                ctrl.defined = 1'b1;
                ctrl.alu     = ALU_ADD;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb_en   = 1'b1;
                ctrl.mem_sgn = (opcode == OP_LDBS) || (opcode == OP_LDHS);
                if (opcode == OP_LDW)       ctrl.msz = MSZ_W;
                else if (opcode >= OP_LDH)  ctrl.msz = MSZ_H;
                else                        ctrl.msz = MSZ_B;
            end
            OP_STB, OP_STH, OP_STW: begin
                ctrl.fmt     = FMT_I;
                ctrl.defined = 1'b1;
                ctrl.alu     = ALU_ADD;
                ctrl.mem_wr  = 1'b1;
                if (opcode == OP_STW)       ctrl.msz = MSZ_W;
                else if (opcode == OP_STH)  ctrl.msz = MSZ_H;
                else                        ctrl.msz = MSZ_B;
            end
            OP_LLO, OP_LHI: begin
                ctrl.fmt       = FMT_I;
                ctrl.defined   = 1'b1;
                ctrl.alu       = (opcode == OP_LHI) ? ALU_LHI : ALU_LLO;
                ctrl.wb_en     = 1'b1;
                ctrl.noreg_req = 3'b100;
            end
            OP_JMP, OP_JEQ, OP_JNE, OP_JGT, OP_JGE, OP_JLT, OP_JLE: begin
                ctrl.fmt       = FMT_I;
                ctrl.defined   = 1'b1;
                ctrl.alu       = ALU_ADD;
                ctrl.br_en     = 1'b1;
                ctrl.brc       = brc_e'(3'(opcode - OP_JMP));
                ctrl.noreg_req = 3'b010;
            end
            OP_CMP: begin
                ctrl.fmt       = FMT_R;
                ctrl.defined   = 1'b1;
                ctrl.alu       = ALU_CMP;
                ctrl.flag_wr   = 1'b1;
                ctrl.noreg_req = 3'b001;
            end
            OP_INC, OP_DEC: begin
                ctrl.fmt       = FMT_R;
                ctrl.defined   = 1'b1;
                ctrl.alu       = (opcode == OP_DEC) ? ALU_DEC : ALU_INC;
                ctrl.wb_en     = 1'b1;
                ctrl.noreg_req = 3'b010;
            end
            OP_SHL, OP_SHR: begin
                ctrl.fmt      = FMT_R;
                ctrl.defined  = 1'b1;
                ctrl.alu      = (opcode == OP_SHR) ? ALU_SHR : ALU_SHL;
                ctrl.wb_en    = 1'b1;
                ctrl.shift_ok = 1'b1;
            end
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT, OP_XOR, OP_NAND, OP_NOR, OP_XNOR: begin
                ctrl.fmt       = FMT_R;
                ctrl.defined   = 1'b1;
                ctrl.alu       = alu_e'(5'(opcode - OP_ADD) + ALU_ADD);
                ctrl.wb_en     = 1'b1;
                ctrl.noreg_req = (opcode == OP_NOT) ? 3'b010 : 3'b000;
            end
            OP_INT: begin
                ctrl.fmt       = FMT_I;
                ctrl.defined   = 1'b1;
                ctrl.is_int    = 1'b1;
                ctrl.noreg_req = 3'b110;
            end
            OP_IADD, OP_ISUB: begin
                ctrl.fmt     = FMT_I;
                ctrl.defined = 1'b1;
                ctrl.alu     = (opcode == OP_ISUB) ? ALU_SUB : ALU_ADD;
                ctrl.wb_en   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/idec_legal.sv
module idec_legal
    import idec_pkg::*;
#(
    parameter logic [RIDX_W-1:0] NOREG = '1
) (
    input  fmt_e               fmt,
    input  logic               defined,
    input  logic               shift_ok,
    input  logic               is_int,
    input  logic [2:0]         noreg_req,
    input  logic [RIDX_W-1:0]  fld_a,
    input  logic [RIDX_W-1:0]  fld_b,
    input  logic [RIDX_W-1:0]  fld_c,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [CODE_W-1:0]  imm_hi,
    output logic               illegal
);
    localparam int NFLD = 3;

    logic [NFLD-1:0][RIDX_W-1:0] flds;
    logic [NFLD-1:0]             fld_bad;
    logic                        shamt_bad;
    logic                        int_bad;

    assign flds = {fld_a, fld_b, fld_c};

    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        assign fld_bad[i] = noreg_req[i] && (flds[i] != NOREG);
    end

    assign shamt_bad = (fmt == FMT_R) && !shift_ok && (shamt != '0);
    assign int_bad   = is_int && (imm_hi != '0);
    assign illegal   = !defined || (|fld_bad) || shamt_bad || int_bad;

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import idec_pkg::*;
#(
    parameter bit                REG_OUT = 1'b1,
    parameter logic [RIDX_W-1:0] NOREG   = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    output logic        out_valid,
    output logic [1:0]  fmt,
    output logic [4:0]  src_a,
    output logic [4:0]  src_b,
    output logic [4:0]  dst,
    output logic [4:0]  shamt,
    output logic [15:0] imm,
    output logic [25:0] jaddr,
    output logic [4:0]  alu_op,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [1:0]  mem_size,
    output logic        mem_signed,
    output logic        br_en,
    output logic [2:0]  br_cond,
    output logic        wb_en,
    output logic        flag_wr,
    output logic        int_req,
    output logic [7:0]  int_code,
    output logic        irt,
    output logic        halt,
    output logic        illegal
);
    logic [OPC_W-1:0]   opcode;
    logic [RIDX_W-1:0]  fld_a, fld_b, fld_c;
    logic [SHAMT_W-1:0] fld_sh;
    logic [IMM_W-1:0]   fld_imm;
    logic [ADDR_W-1:0]  fld_addr;
    ctrl_t              ctrl;
    logic               bad;
    dec_t               dec_d;
    dec_t               out_dec;
    logic               out_vld;

    idec_fields u_fields (
        .instr  (instr),
        .opcode (opcode),
        .fld_a  (fld_a),
        .fld_b  (fld_b),
        .fld_c  (fld_c),
        .shamt  (fld_sh),
        .imm    (fld_imm),
        .jaddr  (fld_addr)
    );

    idec_ctrl u_ctrl (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    idec_legal #(.NOREG(NOREG)) u_legal (
        .fmt       (ctrl.fmt),
        .defined   (ctrl.defined),
        .shift_ok  (ctrl.shift_ok),
        .is_int    (ctrl.is_int),
        .noreg_req (ctrl.noreg_req),
        .fld_a     (fld_a),
        .fld_b     (fld_b),
        .fld_c     (fld_c),
        .shamt     (fld_sh),
        .imm_hi    (fld_imm[IMM_W-1:CODE_W]),
        .illegal   (bad)
    );

    // Assemble the decode; an illegal word drops every state-changing control
    always_comb begin
        dec_d          = '0;
        dec_d.fmt      = ctrl.fmt;
        dec_d.src_a    = fld_a;
        dec_d.src_b    = fld_b;
        dec_d.dst      = (ctrl.fmt == FMT_R) ? fld_c : fld_b;
        dec_d.shamt    = fld_sh;
        dec_d.imm      = fld_imm;
        dec_d.jaddr    = fld_addr;
        dec_d.alu      = ctrl.alu;
        dec_d.msz      = ctrl.msz;
        dec_d.mem_sgn  = ctrl.mem_sgn;
        dec_d.brc      = ctrl.brc;
        dec_d.int_code = fld_imm[CODE_W-1:0];
        dec_d.illegal  = bad;
        dec_d.mem_rd   = ctrl.mem_rd  && !bad;
        dec_d.mem_wr   = ctrl.mem_wr  && !bad;
        dec_d.br_en    = ctrl.br_en   && !bad;
        dec_d.wb_en    = ctrl.wb_en   && !bad;
        dec_d.flag_wr  = ctrl.flag_wr && !bad;
        dec_d.int_req  = ctrl.is_int  && !bad;
        dec_d.irt      = ctrl.is_irt  && !bad;
        dec_d.halt     = ctrl.is_halt && !bad;
    end

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic vld;
            dec_t dec;
        } stage_t;

        stage_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            st_d.dec = dec_d;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign out_dec = st_q.dec;
        assign out_vld = st_q.vld;

        // R13
        valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (out_valid == $past(in_valid)));
    end else begin : g_comb
        assign out_dec = dec_d;
        assign out_vld = in_valid;
    end

    assign out_valid  = out_vld;
    assign fmt        = out_dec.fmt;
    assign src_a      = out_dec.src_a;
    assign src_b      = out_dec.src_b;
    assign dst        = out_dec.dst;
    assign shamt      = out_dec.shamt;
    assign imm        = out_dec.imm;
    assign jaddr      = out_dec.jaddr;
    assign alu_op     = out_dec.alu;
    assign mem_rd     = out_dec.mem_rd;
    assign mem_wr     = out_dec.mem_wr;
    assign mem_size   = out_dec.msz;
    assign mem_signed = out_dec.mem_sgn;
    assign br_en      = out_dec.br_en;
    assign br_cond    = out_dec.brc;
    assign wb_en      = out_dec.wb_en;
    assign flag_wr    = out_dec.flag_wr;
    assign int_req    = out_dec.int_req;
    assign int_code   = out_dec.int_code;
    assign irt        = out_dec.irt;
    assign halt       = out_dec.halt;
    assign illegal    = out_dec.illegal;

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |->
        !(wb_en || flag_wr || mem_rd || mem_wr || br_en || int_req || irt || halt));

    // R7
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(mem_rd && mem_wr));

    // R3
    shamt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && fmt == FMT_R && shamt != '0) |->
        (alu_op == ALU_SHL || alu_op == ALU_SHR));

    // R5
    int_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int_req) |-> (imm[IMM_W-1:CODE_W] == '0 && int_code == imm[CODE_W-1:0]));

    // R1
    fmt_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt == FMT_NONE) |-> illegal);

endmodule

// File: tb/tb_instr_decoder.sv
`timescale 1ns/1ps
module tb_instr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        out_valid;
    logic [1:0]  fmt;
    logic [4:0]  src_a, src_b, dst, shamt;
    logic [15:0] imm;
    logic [25:0] jaddr;
    logic [4:0]  alu_op;
    logic        mem_rd, mem_wr;
    logic [1:0]  mem_size;
    logic        mem_signed, br_en;
    logic [2:0]  br_cond;
    logic        wb_en, flag_wr, int_req;
    logic [7:0]  int_code;
    logic        irt, halt, illegal;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    instr_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .out_valid(out_valid), .fmt(fmt), .src_a(src_a), .src_b(src_b),
        .dst(dst), .shamt(shamt), .imm(imm), .jaddr(jaddr), .alu_op(alu_op),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_size(mem_size),
        .mem_signed(mem_signed), .br_en(br_en), .br_cond(br_cond),
        .wb_en(wb_en), .flag_wr(flag_wr), .int_req(int_req),
        .int_code(int_code), .irt(irt), .halt(halt), .illegal(illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rw(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [4:0] c,
                                       input logic [4:0] sh);
        return {op, a, b, c, sh, 6'd0};
    endfunction

    function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [15:0] v);
        return {op, a, b, v};
    endfunction

    // Expected format per R1
    function automatic logic [1:0] exp_fmt(input int op);
        if (op <= 2) return 2'd0;
        if (op <= 'h13) return 2'd1;
        if (op <= 'h21) return 2'd0;
        if (op == 'h22) return 2'd1;
        if (op <= 'h24) return 2'd0;
        if (op <= 'h26) return 2'd1;
        return 2'd3;
    endfunction

    // Expected ALU code per R9
    function automatic logic [4:0] exp_alu(input int op);
        case (op)
            'h01: return 5'd1;
            'h02: return 5'd2;
            'h0B: return 5'd17;
            'h0C: return 5'd18;
            'h14: return 5'd16;
            'h15: return 5'd14;
            'h16: return 5'd15;
            'h17: return 5'd12;
            'h18: return 5'd13;
            'h25: return 5'd3;
            'h26: return 5'd4;
            default: begin
                if (op >= 'h03 && op <= 'h13) return 5'd3;
                if (op >= 'h19 && op <= 'h21) return 5'(op - 'h19 + 3);
                return 5'd0;
            end
        endcase
    endfunction

    // Expected writeback per R10
    function automatic logic exp_wb(input int op);
        return (op >= 1 && op <= 7) || op == 'h0B || op == 'h0C ||
               (op >= 'h15 && op <= 'h21) || op == 'h25 || op == 'h26;
    endfunction

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr    = w;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R13", "out_valid in reset", 32'(out_valid), 0);
        chk("R13", "illegal in reset", 32'(illegal), 0);
        chk("R13", "wb_en in reset", 32'(wb_en), 0);
        chk("R13", "imm in reset", 32'(imm), 0);
    endtask

    task automatic t_sweep;
        for (int op = 0; op < 64; op++) begin
            logic [31:0] w;
            logic [1:0] ef;
            ef = exp_fmt(op);
            w = (ef == 2'd1) ? iw(6'(op), 5'd31, 5'd31, 16'h0005)
                             : rw(6'(op), 5'd31, 5'd31, 5'd31, 5'd0);
            apply(w);
            chk("R1", $sformatf("fmt op 0x%0h", op), 32'(fmt), 32'(ef));
            chk(op > 'h26 ? "R2" : "R1", $sformatf("illegal op 0x%0h", op),
                32'(illegal), 32'(op > 'h26));
            chk("R9", $sformatf("alu_op op 0x%0h", op), 32'(alu_op), 32'(exp_alu(op)));
            chk("R10", $sformatf("wb_en op 0x%0h", op), 32'(wb_en), 32'(exp_wb(op)));
            chk("R10", $sformatf("flag_wr op 0x%0h", op), 32'(flag_wr), 32'(op == 'h14));
            if (op > 'h26)
                chk("R12", $sformatf("quiet op 0x%0h", op),
                    32'({wb_en, flag_wr, mem_rd, mem_wr, br_en, int_req, irt, halt}), 0);
        end
    endtask

    task automatic t_shift;
        apply(rw(6'h19, 5'd1, 5'd2, 5'd3, 5'd0));
        chk("R3", "ADD shamt 0 legal", 32'(illegal), 0);
        chk("R10", "ADD wb_en", 32'(wb_en), 1);
        apply(rw(6'h19, 5'd1, 5'd2, 5'd3, 5'd3));
        chk("R3", "ADD shamt 3 illegal", 32'(illegal), 1);
        chk("R12", "ADD shamt 3 wb_en", 32'(wb_en), 0);
        apply(rw(6'h17, 5'd1, 5'd31, 5'd3, 5'd3));
        chk("R3", "SHL shamt 3 legal", 32'(illegal), 0);
        chk("R3", "SHL shamt out", 32'(shamt), 3);
        apply(rw(6'h18, 5'd1, 5'd31, 5'd3, 5'd31));
        chk("R3", "SHR shamt 31 legal", 32'(illegal), 0);
        apply(rw(6'h00, 5'd31, 5'd31, 5'd31, 5'd1));
        chk("R3", "NOP shamt 1 illegal", 32'(illegal), 1);
    endtask

    task automatic t_noreg;
        apply(rw(6'h1D, 5'd1, 5'd5, 5'd2, 5'd0));
        chk("R4", "NOT field B used", 32'(illegal), 1);
        apply(rw(6'h1D, 5'd1, 5'd31, 5'd2, 5'd0));
        chk("R4", "NOT field B noreg", 32'(illegal), 0);
        apply(rw(6'h14, 5'd1, 5'd2, 5'd7, 5'd0));
        chk("R4", "CMP field C used", 32'(illegal), 1);
        chk("R12", "CMP illegal flag_wr", 32'(flag_wr), 0);
        apply(rw(6'h14, 5'd1, 5'd2, 5'd31, 5'd0));
        chk("R4", "CMP field C noreg", 32'(illegal), 0);
        apply(iw(6'h0B, 5'd3, 5'd4, 16'h1234));
        chk("R4", "LLO field A used", 32'(illegal), 1);
        apply(iw(6'h0B, 5'd31, 5'd4, 16'h1234));
        chk("R4", "LLO field A noreg", 32'(illegal), 0);
        chk("R6", "LLO dst", 32'(dst), 4);
        apply(iw(6'h0A, 5'd2, 5'd6, 16'h0000));
        chk("R4", "STW both fields", 32'(illegal), 0);
        apply(rw(6'h17, 5'd1, 5'd4, 5'd3, 5'd0));
        chk("R4", "SHL field B unchecked", 32'(illegal), 0);
        apply(rw(6'h24, 5'd0, 5'd31, 5'd31, 5'd0));
        chk("R4", "HLT field A used", 32'(illegal), 1);
        chk("R12", "HLT illegal halt", 32'(halt), 0);
        apply(iw(6'h0E, 5'd7, 5'd5, 16'h0010));
        chk("R4", "JEQ field B used", 32'(illegal), 1);
        chk("R12", "JEQ illegal br_en", 32'(br_en), 0);
    endtask

    task automatic t_fields;
        apply(iw(6'h06, 5'd4, 5'd9, 16'hFFF0));
        chk("R6", "src_a", 32'(src_a), 4);
        chk("R6", "src_b", 32'(src_b), 9);
        chk("R6", "I dst", 32'(dst), 9);
        chk("R6", "imm", 32'(imm), 32'hFFF0);
        chk("R6", "jaddr", 32'(jaddr), 32'({5'd4, 5'd9, 16'hFFF0}));
        chk("R7", "LDHS mem_rd", 32'(mem_rd), 1);
        chk("R7", "LDHS size", 32'(mem_size), 1);
        chk("R7", "LDHS signed", 32'(mem_signed), 1);
        apply(iw(6'h08, 5'd2, 5'd6, 16'h0010));
        chk("R7", "STB mem_wr", 32'(mem_wr), 1);
        chk("R7", "STB mem_rd", 32'(mem_rd), 0);
        chk("R7", "STB size", 32'(mem_size), 0);
        apply(iw(6'h07, 5'd2, 5'd6, 16'h0010));
        chk("R7", "LDW size", 32'(mem_size), 2);
        chk("R7", "LDW signed", 32'(mem_signed), 0);
        apply(iw(6'h09, 5'd2, 5'd6, 16'h0010));
        chk("R7", "STH size", 32'(mem_size), 1);
        apply(rw(6'h1A, 5'd1, 5'd2, 5'd3, 5'd0));
        chk("R6", "R dst", 32'(dst), 3);
        chk("R6", "R src_b", 32'(src_b), 2);
    endtask

    task automatic t_branch;
        for (int k = 0; k < 7; k++) begin
            apply(iw(6'(8'h0D + k), 5'd7, 5'd31, 16'hFF00));
            chk("R8", $sformatf("br_en jump %0d", k), 32'(br_en), 1);
            chk("R8", $sformatf("br_cond jump %0d", k), 32'(br_cond), 32'(k));
            chk("R8", $sformatf("legal jump %0d", k), 32'(illegal), 0);
        end
        apply(rw(6'h19, 5'd1, 5'd2, 5'd3, 5'd0));
        chk("R8", "ADD br_en", 32'(br_en), 0);
    endtask

    task automatic t_int;
        apply(iw(6'h22, 5'd31, 5'd31, 16'h00A5));
        chk("R5", "INT int_req", 32'(int_req), 1);
        chk("R5", "INT code", 32'(int_code), 32'hA5);
        chk("R5", "INT legal", 32'(illegal), 0);
        apply(iw(6'h22, 5'd31, 5'd31, 16'h01A5));
        chk("R5", "INT high bits illegal", 32'(illegal), 1);
        chk("R12", "INT illegal int_req", 32'(int_req), 0);
    endtask

    task automatic t_sys;
        apply(rw(6'h23, 5'd31, 5'd31, 5'd31, 5'd0));
        chk("R11", "IRT irt", 32'(irt), 1);
        chk("R11", "IRT halt", 32'(halt), 0);
        apply(rw(6'h24, 5'd31, 5'd31, 5'd31, 5'd0));
        chk("R11", "HLT halt", 32'(halt), 1);
        chk("R11", "HLT irt", 32'(irt), 0);
    endtask

    task automatic t_valid;
        @(negedge clk);
        in_valid = 1'b0;
        instr    = rw(6'h19, 5'd1, 5'd2, 5'd3, 5'd0);
        @(negedge clk);
        chk("R13", "out_valid low", 32'(out_valid), 0);
        chk("R13", "decode follows word", 32'(dst), 3);
        in_valid = 1'b1;
        instr    = iw(6'h25, 5'd1, 5'd8, 16'h0042);
        chk("R13", "no combinational path", 32'(dst), 3);
        @(negedge clk);
        chk("R13", "out_valid high", 32'(out_valid), 1);
        chk("R13", "decode one cycle later", 32'(dst), 8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "out_valid after reset", 32'(out_valid), 0);
        t_sweep();
        t_shift();
        t_noreg();
        t_fields();
        t_branch();
        t_int();
        t_sys();
        t_valid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule